// File: doc/BRIEF.md
# Attribute-Controlled Configuration Register Bank

This block holds a small bank of 32-bit configuration words behind a simple synchronous bus. The bus carries a select, a write flag, a byte address, four byte-lane enables and write data. Each bit of every word has a fixed access policy, set at elaboration through mask tables in the package. A bit can be read-only, read/write, write-1-to-clear, write-once, or lockable. A lockable bit is writable only while a designated lock bit is clear. Status logic elsewhere in the chip can raise write-1-to-clear bits through per-bit event inputs.

There are two synchronous active-low resets. The power-on reset restores every bit and clears the write-once history. The warm reset restores every bit except the write-once bits, which keep their value and stay locked. While either reset is held, strap inputs are sampled into selected default bits. Every access returns a ready pulse one clock later. This includes accesses to addresses that decode to no word: a read there returns zero and a write there changes nothing.

Word map, by byte address bits [3:2]:
- Word 0 (0x00): control. Bits 7:0 are read/write (default 0x00). Bits 15:8 are lockable (default 0x5A). Bit 16 is the lock bit, write-once (default 0). Bits 31:24 are read-only strap copies. All other bits are read-only zero.
- Word 1 (0x04): events. Bits 7:0 are write-1-to-clear. All other bits are read-only zero.
- Word 2 (0x08): bits 15:0 are write-once (default 0). Bits 31:16 are a read-only constant 0x7E01.
- Word 3 (0x0C): bits 15:0 are read/write, with bits 7:0 defaulting to the straps and bits 15:8 defaulting to 0. Bits 31:16 are read-only zero.

Top module: `cfg_reg_bank`

## Requirements
- R1: Read-only bits (word 0 bits 31:17 and 15:..., word 2 bits 31:16, and all bits outside the listed fields) never change on a bus write. In particular, word 2 bits 31:16 always read 0x7E01.
- R2: Read/write bits take the write data only in the byte lanes whose enable is 1 (enable bit n covers data bits 8n+7:8n). Disabled lanes keep their old value.
- R3: Writing 1 to a write-1-to-clear bit (word 1 bits 7:0) in an enabled lane clears that bit. Writing 0 leaves it unchanged.
- R4: A 1 on hwSet bit 32*w+b sets write-1-to-clear bit b of word w. If a set and a bus clear hit the same bit in the same cycle, the bit ends at 1. A 1 on hwSet for any other bit has no effect.
- R5: A write-once bit (word 2 bits 15:0, word 0 bit 16) takes the first write in which its byte lane is enabled. After that it ignores writes until the next power-on reset.
- R6: Word 0 bits 15:8 behave as read/write while word 0 bit 16 is 0, and as read-only once it is 1. A write that sets bit 16 still updates bits 15:8 in that same cycle.
- R7: An access whose byte address bits [7:2] are 4 or more gets a ready pulse. A read there returns 0 for any byte-enable pattern, and a write there changes no word. Such addresses do not alias onto words 0–3.
- R8: busReady is 1 in exactly the cycle after each cycle with busSel high. On a read, busRdata carries the addressed word in that cycle. At all other times, including right after reset, busRdata is 0.
- R9: Word 0 bits 31:24 and word 3 bits 7:0 load strapIn while a reset is held. Changes to strapIn after reset do not alter the read value.
- R10: Warm reset restores the defaults of all bits except write-once bits, which keep their value and their written state. Power-on reset restores all defaults and makes write-once bits writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, synchronous, active low |
| rstN | input | 1 | Warm reset, synchronous, active low |
| strapIn | input | 8 | Strap pins sampled during reset |
| hwSet | input | 128 | Per-bit event set inputs, 32 per word |
| busSel | input | 1 | Access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busBe | input | 4 | Byte-lane enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completion pulse |

## Verification
A wrong stored value in this bank is visible only through a read, and it appears in busRdata one clock after the read strobe. The bench therefore follows every write with a read-back of the affected word, and checks the word a misdecoded address would alias onto. Errors in the write-once history or the lock state stay hidden until a later write is wrongly accepted or refused. For that reason the bench writes each such field a second time, after a warm reset and after a power-on reset, and reads it back. A missing or late ready pulse shows in the cycle right after the access.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int NUM_REGS = 4;           // power of two
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int STRAP_W  = 8;
  localparam int LOCK_REG = 0;
  localparam int LOCK_BIT = 16;

  typedef logic [DATA_W-1:0] word_t;

  // per-bit policy tables; a bit in none of them is read-only
  localparam word_t RW_MASK  [NUM_REGS] = '{32'h0000_00FF, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF};
  localparam word_t LK_MASK  [NUM_REGS] = '{32'h0000_FF00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
  localparam word_t W1C_MASK [NUM_REGS] = '{32'h0000_0000, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000};
  localparam word_t WO_MASK  [NUM_REGS] = '{32'h0001_0000, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000};
  localparam word_t DEF_VAL  [NUM_REGS] = '{32'h0000_5A00, 32'h0000_0000, 32'h7E01_0000, 32'h0000_0000};
  localparam word_t STRAP_MASK [NUM_REGS] = '{32'hFF00_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF};

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             hit;
    logic [SEL_W-1:0] sel;
    logic [LANES-1:0] be;
  } strobe_t;

  function automatic word_t resetValue(input int idx, input logic [STRAP_W-1:0] straps);
    word_t strapWord;
    strapWord = {(DATA_W/STRAP_W){straps}};
    return (DEF_VAL[idx] & ~STRAP_MASK[idx]) | (strapWord & STRAP_MASK[idx]);
  endfunction

endpackage

// File: rtl/cfg_bank_ctrl.sv
module cfg_bank_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busBe,
  output strobe_t           strb,
  output logic              busReady
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;

  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    strb.wr  = busSel && busWr;
    strb.rd  = busSel && !busWr;
    strb.hit = wordIdx < IDX_W'(NUM_REGS);
    strb.sel = busAddr[SEL_W+1:2];
    strb.be  = busBe;
  end

  // every access, mapped or not, completes one clock later
  always_ff @(posedge clk) begin
    if (!porRstN || !rstN) busReady <= 1'b0;
    else                   busReady <= busSel;
  end

endmodule

// File: rtl/cfg_bank_datapath.sv
module cfg_bank_datapath
  import cfg_bank_pkg::*;
(
  input  logic                       clk,
  input  logic                       porRstN,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  word_t                      wdata,
  input  logic [STRAP_W-1:0]         strapIn,
  input  logic [NUM_REGS*DATA_W-1:0] hwSet,
  output word_t                      rdata
);

  word_t laneMask;
  word_t regVal [NUM_REGS];
  logic  lockQ;

  always_comb begin
    for (int l = 0; l < LANES; l++) laneMask[l*8 +: 8] = {8{strb.be[l]}};
  end

  assign lockQ = regVal[LOCK_REG][LOCK_BIT];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    word_t valQ, onceQ, wrHit, rwEff, woTake, hwBits, nextVal, rstVal;

    assign wrHit  = (strb.wr && strb.hit && strb.sel == SEL_W'(r)) ? laneMask : '0;
    assign rwEff  = RW_MASK[r] | (LK_MASK[r] & {DATA_W{~lockQ}});
    assign woTake = wrHit & WO_MASK[r] & ~onceQ;
    assign hwBits = hwSet[r*DATA_W +: DATA_W] & W1C_MASK[r];
    assign rstVal = resetValue(r, strapIn);

    always_comb begin
      nextVal = valQ;
      nextVal = (nextVal & ~(wrHit & rwEff)) | (wdata & wrHit & rwEff);
      nextVal = (nextVal & ~woTake) | (wdata & woTake);
      nextVal = nextVal & ~(wrHit & W1C_MASK[r] & wdata);
      nextVal = nextVal | hwBits;          // hardware set beats software clear
    end

    always_ff @(posedge clk) begin
      if (!porRstN) begin
        valQ  <= rstVal;
        onceQ <= '0;
      end else if (!rstN) begin
        valQ  <= (rstVal & ~WO_MASK[r]) | (valQ & WO_MASK[r]);
      end else begin
        valQ  <= nextVal;
        onceQ <= onceQ | woTake;
      end
    end

    assign regVal[r] = valQ;
  end

  always_ff @(posedge clk) begin
    if (!porRstN || !rstN)      rdata <= '0;
    else if (strb.rd && strb.hit) rdata <= regVal[strb.sel];
    else                        rdata <= '0;
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  logic                       rstN,
  input  logic [STRAP_W-1:0]         strapIn,
  input  logic [NUM_REGS*DATA_W-1:0] hwSet,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [LANES-1:0]           busBe,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       busReady
);

  strobe_t strb;

  cfg_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busBe(busBe),
    .strb(strb), .busReady(busReady)
  );

  cfg_bank_datapath u_dp (
    .clk(clk), .porRstN(porRstN), .rstN(rstN),
    .strb(strb), .wdata(busWdata), .strapIn(strapIn), .hwSet(hwSet),
    .rdata(busRdata)
  );

endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                       clk,
  input logic                       porRstN,
  input logic                       rstN,
  input logic [STRAP_W-1:0]         strapIn,
  input logic [NUM_REGS*DATA_W-1:0] hwSet,
  input logic                       busSel,
  input logic                       busWr,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [LANES-1:0]           busBe,
  input logic [DATA_W-1:0]          busWdata,
  input logic [DATA_W-1:0]          busRdata,
  input logic                       busReady
);

  localparam int IDX_W = ADDR_W - 2;

  logic [STRAP_W-1:0] strapCap;
  logic               rdUnmapped, rdWord0, rdWord2;

  always_ff @(posedge clk) begin
    if (!porRstN || !rstN) strapCap <= strapIn;
  end

  assign rdUnmapped = busSel && !busWr && (busAddr[ADDR_W-1:2] >= IDX_W'(NUM_REGS));
  assign rdWord0    = busSel && !busWr && (busAddr[ADDR_W-1:2] == IDX_W'(0));
  assign rdWord2    = busSel && !busWr && (busAddr[ADDR_W-1:2] == IDX_W'(2));

  assert_ready_after_sel_R8: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    busSel |=> busReady);
  assert_no_stray_ready_R8: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    !busSel |=> !busReady);
  assert_idle_rdata_zero_R8: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    !busReady |-> busRdata == '0);
  assert_unmapped_reads_zero_R7: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    rdUnmapped |=> busRdata == '0);
  assert_strap_held_R9: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    rdWord0 |=> busRdata[31:24] == strapCap);
  assert_ro_constant_R1: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    rdWord2 |=> busRdata[31:16] == 16'h7E01);

endmodule

bind cfg_reg_bank cfg_reg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_cfg_reg_bank.sv
module sim_cfg_reg_bank;

  logic         clk = 1'b0;
  logic         porRstN = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   strapIn = 8'hA7;
  logic [127:0] hwSet = '0;
  logic         busSel = 1'b0;
  logic         busWr = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [3:0]   busBe = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         busReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  cfg_reg_bank u0 (
    .clk(clk), .porRstN(porRstN), .rstN(rstN), .strapIn(strapIn), .hwSet(hwSet),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 4'hF, 32'hA700_5A00, 8'd9},   // R9 defaults with straps
    '{1'b0, 8'h0C, 4'hF, 32'h0000_00A7, 8'd9},
    '{1'b0, 8'h08, 4'hF, 32'h7E01_0000, 8'd9},
    '{1'b1, 8'h00, 4'hF, 32'hFFFF_FFFF, 8'd0},
    '{1'b0, 8'h00, 4'hF, 32'hA701_FFFF, 8'd6},   // R6 lock set, field written same cycle; R1
    '{1'b1, 8'h00, 4'hF, 32'h0000_0000, 8'd0},
    '{1'b0, 8'h00, 4'hF, 32'hA701_FF00, 8'd6},   // R6 locked field holds
    '{1'b1, 8'h0C, 4'h1, 32'hFFFF_FF34, 8'd0},
    '{1'b0, 8'h0C, 4'hF, 32'h0000_0034, 8'd2},   // R2 lane 0 only
    '{1'b1, 8'h0C, 4'h2, 32'hFFFF_12FF, 8'd0},
    '{1'b0, 8'h0C, 4'hF, 32'h0000_1234, 8'd2},   // R2 lane 1 only
    '{1'b1, 8'h08, 4'h1, 32'h0000_3355, 8'd0},
    '{1'b0, 8'h08, 4'hF, 32'h7E01_0055, 8'd5},   // R5 only enabled lane taken
    '{1'b1, 8'h08, 4'h3, 32'h0000_AAAA, 8'd0},
    '{1'b0, 8'h08, 4'hF, 32'h7E01_AA55, 8'd5},   // R5 lane 0 held, lane 1 first write
    '{1'b1, 8'h08, 4'hF, 32'hFFFF_FFFF, 8'd0},
    '{1'b0, 8'h08, 4'hF, 32'h7E01_AA55, 8'd5},   // R5 and R1
    '{1'b1, 8'h40, 4'hF, 32'hFFFF_FFFF, 8'd0},
    '{1'b0, 8'h40, 4'hF, 32'h0000_0000, 8'd7},   // R7 unmapped reads zero
    '{1'b0, 8'h41, 4'h1, 32'h0000_0000, 8'd7},
    '{1'b0, 8'h42, 4'h3, 32'h0000_0000, 8'd7},
    '{1'b0, 8'h00, 4'hF, 32'hA701_FF00, 8'd7},   // R7 no alias onto word 0
    '{1'b0, 8'h0C, 4'hF, 32'h0000_1234, 8'd7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic access(input logic wr, input logic [7:0] addr, input logic [3:0] be,
                        input logic [31:0] wdata, output logic [31:0] rd, output logic rdy);
    busSel = 1'b1; busWr = wr; busAddr = addr; busBe = be; busWdata = wdata;
    @(negedge clk);
    rd = busRdata; rdy = busReady;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic wrWord(input logic [7:0] addr, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] rd; logic rdy;
    access(1'b1, addr, be, d, rd, rdy);
    check("R8 write ready", {31'd0, rdy}, 32'd1);
  endtask

  task automatic rdCheck(input string tag, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] rd; logic rdy;
    access(1'b0, addr, 4'hF, 32'd0, rd, rdy);
    check("R8 read ready", {31'd0, rdy}, 32'd1);
    check(tag, rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    check("R8 reset ready", {31'd0, busReady}, 32'd0);
    check("R8 reset rdata", busRdata, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] rd; logic rdy;
      access(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].data, rd, rdy);
      check($sformatf("R8 ready vec %0d", i), {31'd0, rdy}, 32'd1);
      if (!VECS[i].wr) check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].data);
    end

    @(negedge clk);
    check("R8 idle ready", {31'd0, busReady}, 32'd0);

    // event bits: hardware set, W1C clear, collision
    hwSet[63:32] = 32'h0000_010F;
    @(negedge clk);
    hwSet = '0;
    rdCheck("R4 hw set, non-W1C ignored", 8'h04, 32'h0000_000F);
    wrWord(8'h04, 4'hF, 32'h0000_0005);
    rdCheck("R3 write 1 clears", 8'h04, 32'h0000_000A);
    wrWord(8'h04, 4'hF, 32'h0000_0000);
    rdCheck("R3 write 0 keeps", 8'h04, 32'h0000_000A);
    wrWord(8'h04, 4'hE, 32'h0000_000A);
    rdCheck("R3 disabled lane keeps", 8'h04, 32'h0000_000A);
    hwSet[63:32] = 32'h0000_0002;
    wrWord(8'h04, 4'hF, 32'h0000_0002);
    hwSet = '0;
    rdCheck("R4 set wins over clear", 8'h04, 32'h0000_000A);
    wrWord(8'h04, 4'hF, 32'h0000_000A);
    rdCheck("R3 clear all", 8'h04, 32'h0000_0000);

    // warm reset with new straps
    strapIn = 8'h3C; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rdCheck("R10 warm word0", 8'h00, 32'h3C01_5A00);
    rdCheck("R10 warm word1", 8'h04, 32'h0000_0000);
    rdCheck("R10 warm keeps write-once", 8'h08, 32'h7E01_AA55);
    rdCheck("R9 warm strap word3", 8'h0C, 32'h0000_003C);
    wrWord(8'h00, 4'hF, 32'hFFFF_FFFF);
    rdCheck("R6 lock survives warm reset", 8'h00, 32'h3C01_5AFF);
    wrWord(8'h08, 4'hF, 32'h0000_0000);
    rdCheck("R5 write-once survives warm reset", 8'h08, 32'h7E01_AA55);

    // power-on reset
    strapIn = 8'hA7; porRstN = 1'b0;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
    strapIn = 8'h00;
    @(negedge clk);
    rdCheck("R10 por word0", 8'h00, 32'hA700_5A00);
    rdCheck("R10 por word2", 8'h08, 32'h7E01_0000);
    wrWord(8'h00, 4'hF, 32'h0000_FF00);
    rdCheck("R6 unlocked after por", 8'h00, 32'hA700_FF00);
    wrWord(8'h08, 4'hF, 32'h0000_1111);
    rdCheck("R10 write-once free after por", 8'h08, 32'h7E01_1111);
    rdCheck("R9 strap change ignored", 8'h0C, 32'h0000_00A7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule